// File: doc/BRIEF.md
# Hybrid Branch Direction Predictor

This block guesses the direction of conditional branches by blending two predictors. The first is a table of 2-bit saturating counters selected directly by the branch's word-address bits. The second is a table of the same counters selected by those bits XORed with a global history of recent branch directions. A third table, also selected by the address bits, holds 2-bit counters that decide which of the two components supplies the final answer.

On a lookup, the fetch stage presents the branch's address bits. The block returns the chosen direction and a snapshot made of both component guesses and the history value in use. The history then shifts in the guessed direction at once. When the branch resolves, the back end returns the address bits, the real direction and the snapshot. Training uses only the snapshot values, so later history changes cannot redirect it. When a misprediction is found, a restore port rebuilds the history from the checkpoint plus the real outcome.

Top module: `hyb_bpred`

## Requirements
- R1: After reset every counter in all three tables holds 01 (weakly not taken), the history is zero, and any lookup returns taken=0 with both component guesses 0 and history snapshot 0.
- R2: A counter moves one step toward 11 on a taken training and one step toward 00 on a not-taken training. It saturates at 11 and at 00 and never wraps.
- R3: A component guess is the MSB of its counter. The final direction is the global guess when the chooser counter MSB is 1 and the address-table guess when it is 0. When both guesses agree, the final direction equals them.
- R4: The address table and the chooser are selected by the IDX_W address bits presented on the port, so distinct values select distinct entries.
- R5: The global table entry is the address bits XOR the K-bit history, zero-extended to IDX_W, with the history in bit positions K-1..0.
- R6: Each valid lookup shifts the guessed direction into history bit 0 and drops bit K-1. pred_ghr_o shows the value before the shift, and a cycle with no valid lookup leaves the history unchanged.
- R7: A restore loads {checkpoint[K-2:0], real outcome} into the history. It wins over a valid lookup in the same cycle.
- R8: The chooser trains only when the two snapshot guesses differ. It steps toward 11 when the global guess matched the outcome and toward 00 when the address-table guess did. It is left unchanged when both were right or both were wrong.
- R9: Training of the global table selects its entry with the history snapshot returned on the update port, never the live history.
- R10: With upd_valid_i low, no table entry changes whatever the other update inputs carry.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| pred_valid_i | input | 1 | Lookup is real; shift history |
| pred_pc_i | input | IDX_W | Branch word-address bits for lookup |
| pred_taken_o | output | 1 | Final guessed direction |
| pred_bim_o | output | 1 | Address-table guess (snapshot) |
| pred_gsh_o | output | 1 | Global-table guess (snapshot) |
| pred_ghr_o | output | K | History used by this lookup (snapshot) |
| upd_valid_i | input | 1 | Train tables with a resolved branch |
| upd_pc_i | input | IDX_W | Resolved branch word-address bits |
| upd_taken_i | input | 1 | Real direction |
| upd_bim_i | input | 1 | Snapshot address-table guess |
| upd_gsh_i | input | 1 | Snapshot global-table guess |
| upd_ghr_i | input | K | Snapshot history |
| fix_valid_i | input | 1 | Restore history after a mispredict |
| fix_ghr_i | input | K | Checkpointed history of the mispredicted branch |
| fix_taken_i | input | 1 | Real outcome of the mispredicted branch |

## Verification
The embedded properties check several rules on every cycle: that counters step by one and stick at both ends, that the history shifts or restores as required and holds otherwise, and that the final direction follows the components whenever they agree. Only the directed scenarios can show the table-level effects. These are the chooser's three training cases, entry selection through the XOR with the snapshot rather than the live history, aliasing between address values, and the absence of any change while update is idle. The bench observes each of these through later lookups at the ports.

// File: rtl/hyb_pkg.sv
package hyb_pkg;
  typedef logic [1:0] ctr_t;

  localparam ctr_t CTR_WNT = 2'b01;

  function automatic ctr_t ctr_next(ctr_t cur, logic up);
    if (up) return (cur == 2'b11) ? cur : cur + 2'b01;
    else    return (cur == 2'b00) ? cur : cur - 2'b01;
  endfunction

  function automatic logic ctr_dir(ctr_t cur);
    return cur[1];
  endfunction
endpackage

// File: rtl/hyb_ctr_tbl.sv
module hyb_ctr_tbl
  import hyb_pkg::*;
#(
  parameter int   IDX_W = 6,
  parameter ctr_t INIT  = CTR_WNT
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [IDX_W-1:0] rd_idx_i,
  output logic             rd_dir_o,
  input  logic             wr_en_i,
  input  logic [IDX_W-1:0] wr_idx_i,
  input  logic             wr_up_i
);
  localparam int DEPTH = 1 << IDX_W;

  ctr_t mem_q [DEPTH];
  ctr_t wr_cur;

  assign wr_cur   = mem_q[wr_idx_i];
  assign rd_dir_o = ctr_dir(mem_q[rd_idx_i]);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int i = 0; i < DEPTH; i++) mem_q[i] <= INIT;
    end else if (wr_en_i) begin
      mem_q[wr_idx_i] <= ctr_next(wr_cur, wr_up_i);
    end
  end

  a_r2_top_sat: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_en_i && wr_up_i && wr_cur == 2'b11) |=> mem_q[$past(wr_idx_i)] == 2'b11);

  a_r2_bot_sat: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_en_i && !wr_up_i && wr_cur == 2'b00) |=> mem_q[$past(wr_idx_i)] == 2'b00);

  a_r2_step_up: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_en_i && wr_up_i && wr_cur != 2'b11) |=> mem_q[$past(wr_idx_i)] == $past(wr_cur) + 2'b01);

  a_r2_step_dn: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_en_i && !wr_up_i && wr_cur != 2'b00) |=> mem_q[$past(wr_idx_i)] == $past(wr_cur) - 2'b01);
endmodule

// File: rtl/hyb_ghr.sv
module hyb_ghr #(
  parameter int K = 4
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         shift_en_i,
  input  logic         shift_bit_i,
  input  logic         fix_en_i,
  input  logic [K-1:0] fix_ghr_i,
  input  logic         fix_taken_i,
  output logic [K-1:0] ghr_o
);
  logic [K-1:0] ghr_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)         ghr_q <= '0;
    else if (fix_en_i)   ghr_q <= {fix_ghr_i[K-2:0], fix_taken_i};
    else if (shift_en_i) ghr_q <= {ghr_q[K-2:0], shift_bit_i};
  end

  assign ghr_o = ghr_q;

  a_r6_shift: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (shift_en_i && !fix_en_i) |=> ghr_o[K-1:1] == $past(ghr_o[K-2:0]) && ghr_o[0] == $past(shift_bit_i));

  a_r6_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!shift_en_i && !fix_en_i) |=> $stable(ghr_o));

  a_r7_restore: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fix_en_i |=> ghr_o == K'({$past(fix_ghr_i), $past(fix_taken_i)}));
endmodule

// File: rtl/hyb_bpred.sv
module hyb_bpred
  import hyb_pkg::*;
#(
  parameter int IDX_W = 6,
  parameter int K     = 4
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             pred_valid_i,
  input  logic [IDX_W-1:0] pred_pc_i,
  output logic             pred_taken_o,
  output logic             pred_bim_o,
  output logic             pred_gsh_o,
  output logic [K-1:0]     pred_ghr_o,
  input  logic             upd_valid_i,
  input  logic [IDX_W-1:0] upd_pc_i,
  input  logic             upd_taken_i,
  input  logic             upd_bim_i,
  input  logic             upd_gsh_i,
  input  logic [K-1:0]     upd_ghr_i,
  input  logic             fix_valid_i,
  input  logic [K-1:0]     fix_ghr_i,
  input  logic             fix_taken_i
);
  localparam int HASH_PAD = IDX_W - K;

  logic [K-1:0]     ghr;
  logic [IDX_W-1:0] gsh_rd_idx, gsh_wr_idx;
  logic             bim_dir, gsh_dir, cho_dir;
  logic             cho_wr_en;

  assign gsh_rd_idx = pred_pc_i ^ {{HASH_PAD{1'b0}}, ghr};
  assign gsh_wr_idx = upd_pc_i  ^ {{HASH_PAD{1'b0}}, upd_ghr_i};
  assign cho_wr_en  = upd_valid_i && (upd_bim_i != upd_gsh_i);

  hyb_ctr_tbl #(.IDX_W(IDX_W), .INIT(CTR_WNT)) u_bim (
    .clk_i, .rst_ni,
    .rd_idx_i(pred_pc_i), .rd_dir_o(bim_dir),
    .wr_en_i(upd_valid_i), .wr_idx_i(upd_pc_i), .wr_up_i(upd_taken_i)
  );

  hyb_ctr_tbl #(.IDX_W(IDX_W), .INIT(CTR_WNT)) u_gsh (
    .clk_i, .rst_ni,
    .rd_idx_i(gsh_rd_idx), .rd_dir_o(gsh_dir),
    .wr_en_i(upd_valid_i), .wr_idx_i(gsh_wr_idx), .wr_up_i(upd_taken_i)
  );

  // MSB set selects the global component
  hyb_ctr_tbl #(.IDX_W(IDX_W), .INIT(CTR_WNT)) u_cho (
    .clk_i, .rst_ni,
    .rd_idx_i(pred_pc_i), .rd_dir_o(cho_dir),
    .wr_en_i(cho_wr_en), .wr_idx_i(upd_pc_i), .wr_up_i(upd_gsh_i == upd_taken_i)
  );

  hyb_ghr #(.K(K)) u_ghr (
    .clk_i, .rst_ni,
    .shift_en_i(pred_valid_i), .shift_bit_i(pred_taken_o),
    .fix_en_i(fix_valid_i), .fix_ghr_i(fix_ghr_i), .fix_taken_i(fix_taken_i),
    .ghr_o(ghr)
  );

  assign pred_bim_o   = bim_dir;
  assign pred_gsh_o   = gsh_dir;
  assign pred_ghr_o   = ghr;
  assign pred_taken_o = cho_dir ? gsh_dir : bim_dir;

  a_r3_agree: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (pred_bim_o == pred_gsh_o) |-> pred_taken_o == pred_bim_o);

  a_r3_from_comp: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (pred_taken_o == pred_bim_o) || (pred_taken_o == pred_gsh_o));
endmodule

// File: tb/sim_hyb_bpred.sv
module sim_hyb_bpred;
  localparam int CLK_PERIOD = 10;
  localparam int IDX_W = 6;
  localparam int K     = 4;

  logic             clk_i = 1'b0;
  logic             rst_ni = 1'b0;
  logic             pred_valid_i = 1'b0;
  logic [IDX_W-1:0] pred_pc_i = '0;
  logic             pred_taken_o, pred_bim_o, pred_gsh_o;
  logic [K-1:0]     pred_ghr_o;
  logic             upd_valid_i = 1'b0;
  logic [IDX_W-1:0] upd_pc_i = '0;
  logic             upd_taken_i = 1'b0, upd_bim_i = 1'b0, upd_gsh_i = 1'b0;
  logic [K-1:0]     upd_ghr_i = '0;
  logic             fix_valid_i = 1'b0;
  logic [K-1:0]     fix_ghr_i = '0;
  logic             fix_taken_i = 1'b0;

  int n_chk = 0;
  int n_bad = 0;

  always #(CLK_PERIOD/2) clk_i = ~clk_i;

  hyb_bpred #(.IDX_W(IDX_W), .K(K)) u0 (.*);

  task automatic chk(string req, logic [7:0] act, logic [7:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  // lookup without shifting; called just after a negedge
  task automatic peek(logic [IDX_W-1:0] pc, string req, logic tk, logic b, logic g);
    pred_pc_i = pc; pred_valid_i = 1'b0;
    #1;
    chk({req, " taken"}, 8'(pred_taken_o), 8'(tk));
    chk({req, " bim"},   8'(pred_bim_o),   8'(b));
    chk({req, " gsh"},   8'(pred_gsh_o),   8'(g));
  endtask

  task automatic upd(logic [IDX_W-1:0] pc, logic tk, logic b, logic g, logic [K-1:0] h);
    upd_pc_i = pc; upd_taken_i = tk; upd_bim_i = b; upd_gsh_i = g; upd_ghr_i = h;
    upd_valid_i = 1'b1;
    @(negedge clk_i);
    upd_valid_i = 1'b0;
  endtask

  task automatic fix(logic [K-1:0] h, logic tk, logic with_pred);
    fix_ghr_i = h; fix_taken_i = tk; fix_valid_i = 1'b1; pred_valid_i = with_pred;
    @(negedge clk_i);
    fix_valid_i = 1'b0; pred_valid_i = 1'b0;
  endtask

  task automatic t_reset();
    peek(6'd0,  "R1", 1'b0, 1'b0, 1'b0);
    peek(6'd63, "R1", 1'b0, 1'b0, 1'b0);
    chk("R1 ghr", 8'(pred_ghr_o), 8'h0);
  endtask

  task automatic t_saturate();
    upd(6'd16, 1'b1, 1'b0, 1'b0, 4'h0);
    peek(6'd16, "R2 first up", 1'b1, 1'b1, 1'b1);
    upd(6'd16, 1'b1, 1'b0, 1'b0, 4'h0);
    upd(6'd16, 1'b1, 1'b0, 1'b0, 4'h0);
    upd(6'd16, 1'b0, 1'b0, 1'b0, 4'h0);
    peek(6'd16, "R2 top sat", 1'b1, 1'b1, 1'b1);
    upd(6'd16, 1'b0, 1'b0, 1'b0, 4'h0);
    upd(6'd16, 1'b0, 1'b0, 1'b0, 4'h0);
    upd(6'd16, 1'b0, 1'b0, 1'b0, 4'h0);
    upd(6'd16, 1'b1, 1'b0, 1'b0, 4'h0);
    upd(6'd16, 1'b1, 1'b0, 1'b0, 4'h0);
    peek(6'd16, "R2 bot sat", 1'b1, 1'b1, 1'b1);
  endtask

  task automatic t_index();
    peek(6'd17, "R4 neighbour", 1'b0, 1'b0, 1'b0);
    peek(6'd48, "R4 high alias", 1'b0, 1'b0, 1'b0);
  endtask

  task automatic t_history();
    logic [K-1:0] exp_h [5] = '{4'h0, 4'h1, 4'h3, 4'h7, 4'hF};
    upd(6'd20, 1'b1, 1'b0, 1'b0, 4'h0);
    upd(6'd20, 1'b1, 1'b0, 1'b0, 4'h0);
    for (int i = 0; i < 4; i++) begin
      pred_pc_i = 6'd20; pred_valid_i = 1'b1;
      #1;
      chk("R6 snapshot", 8'(pred_ghr_o), 8'(exp_h[i]));
      chk("R6 taken", 8'(pred_taken_o), 8'h1);
      @(negedge clk_i);
    end
    pred_valid_i = 1'b0;
    @(negedge clk_i);
    chk("R6 idle hold", 8'(pred_ghr_o), 8'(exp_h[4]));
  endtask

  task automatic t_restore();
    fix(4'h3, 1'b1, 1'b0);
    chk("R7 restore", 8'(pred_ghr_o), 8'h7);
    pred_pc_i = 6'd20;
    fix(4'h5, 1'b0, 1'b1);
    chk("R7 wins over lookup", 8'(pred_ghr_o), 8'hA);
  endtask

  task automatic t_global();
    // live history is 1010 while training with snapshot 0011
    upd(6'd5, 1'b1, 1'b0, 1'b0, 4'h3);
    upd(6'd5, 1'b1, 1'b0, 1'b0, 4'h3);
    fix(4'h0, 1'b0, 1'b0);
    chk("R5 ghr zero", 8'(pred_ghr_o), 8'h0);
    peek(6'd6, "R5 xor entry", 1'b0, 1'b0, 1'b1);
    peek(6'd5, "R9 snapshot used", 1'b1, 1'b1, 1'b0);
    peek(6'd15, "R9 live not used", 1'b0, 1'b0, 1'b0);
  endtask

  task automatic t_chooser();
    upd(6'd9, 1'b1, 1'b0, 1'b1, 4'h0);   // only global right
    upd(6'd9, 1'b0, 1'b1, 1'b1, 4'h1);   // both wrong
    peek(6'd9, "R8 both wrong keeps global", 1'b1, 1'b0, 1'b1);
    upd(6'd9, 1'b0, 1'b0, 1'b1, 4'h2);   // only bimodal right
    peek(6'd9, "R8 back to bimodal", 1'b0, 1'b0, 1'b1);
    upd(6'd9, 1'b1, 1'b1, 1'b1, 4'h4);   // both right
    peek(6'd9, "R8 both right keeps", 1'b0, 1'b0, 1'b1);
  endtask

  task automatic t_idle_update();
    upd_pc_i = 6'd9; upd_taken_i = 1'b1; upd_bim_i = 1'b0; upd_gsh_i = 1'b1; upd_ghr_i = 4'h0;
    upd_valid_i = 1'b0;
    repeat (3) @(negedge clk_i);
    peek(6'd9, "R10 idle update", 1'b0, 1'b0, 1'b1);
  endtask

  initial begin
    #(CLK_PERIOD * 20000);
    n_chk++; n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk_i);
    rst_ni = 1'b1;
    @(negedge clk_i);
    t_reset();
    t_saturate();
    t_index();
    t_history();
    t_restore();
    t_global();
    t_chooser();
    t_idle_update();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule